// File: doc/BRIEF.md
# CAN Controller Operating Mode Sequencer

This block holds the operating mode of a CAN controller and decides when a mode change asked for by software may take effect. Six modes exist: configuration, disable, normal, listen-only, loop-back and error-recognition. Each cycle it samples a requested mode code. It grants the request at once, defers it, or ignores it. The decision depends on whether a transmission is under way and on whether the bus has been idle long enough.

From the current mode the block drives one-hot control levels for the protocol engine beside it. These are: transmit enable, acknowledge/error-frame generation, internal loop-back routing, acceptance of invalid messages, the module clock gate, an error-counter clear and an interrupt enable mask. An idle detector counts consecutive recessive bits at bit-time ticks. A move to disable from any active mode waits until that counter reports an idle bus.

Top module: `can_mode_seq`

## Requirements
- R1: After reset `cur_mode` is configuration (code 0), `err_clr` is 1 and `irq_mask` is all ones.
- R2: A request for configuration (code 0) is not granted while `tx_busy` is 1. It takes effect on the first clock edge at which `tx_busy` is 0.
- R3: In configuration mode `tx_en`, `ack_en`, `loop_sel` and `accept_bad` are 0, `err_clr` is 1, `clk_en` is 1 and `irq_mask` is all ones.
- R4: The idle counter increments at each `bit_tick` that samples `bus_rx`=1 (recessive), clears at each `bit_tick` that samples `bus_rx`=0 (dominant), and saturates at IDLE_BITS (11).
- R5: A request for disable (code 1) is granted at once from configuration mode. From any other mode it is granted only on an edge at which the idle counter already holds IDLE_BITS.
- R6: In disable mode `clk_en` is 0, `tx_en`, `ack_en`, `loop_sel`, `accept_bad` and `err_clr` are 0, and `irq_mask` has only bit WAKE_BIT (0) set.
- R7: Normal mode (code 2) is the only mode with `tx_en`=1, and it also sets `ack_en`=1.
- R8: Listen-only mode (code 3) sets `accept_bad`=1 with `tx_en`, `ack_en` and `loop_sel` at 0.
- R9: Loop-back mode (code 4) sets `loop_sel`=1 with `tx_en` and `ack_en` at 0.
- R10: Error-recognition mode (code 5) sets `accept_bad`=1 with `tx_en`, `ack_en` and `loop_sel` at 0.
- R11: A request for code 2, 3, 4 or 5 becomes `cur_mode` on the next clock edge.
- R12: A request with code 6 or 7 is ignored and `cur_mode` keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_mode | input | 3 | Requested mode code from software |
| tx_busy | input | 1 | A transmission is in progress |
| bus_rx | input | 1 | Sampled bus level, 1 = recessive |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| cur_mode | output | 3 | Current mode code |
| tx_en | output | 1 | Transmit path enable |
| ack_en | output | 1 | Acknowledge and error-frame generation enable |
| loop_sel | output | 1 | Route transmit path internally to receive path |
| accept_bad | output | 1 | Accept messages that fail checks |
| clk_en | output | 1 | Module clock gate enable |
| err_clr | output | 1 | Error counter clear |
| irq_mask | output | IRQ_W | Interrupt enable mask |

## Verification
Directed sequences cover several cases. A disable request from configuration must be granted at once. A configuration request is held off by a busy transmitter over several cycles. A disable request from normal mode faces a run of recessive ticks broken by one dominant tick, which separates a counter that clears from one that only counts. Exactly ten and then eleven recessive ticks check the threshold edge, and undefined codes check that the mode stays put. Seeded random requests follow, with rare dominant bits, a random tick rate and random busy levels. They are compared each cycle against a bench mode model, which exercises saturation, deferred and immediate grants, and every per-mode output pattern.

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int IDLE_BITS = 11,
  parameter int IRQ_W     = 8,
  parameter int WAKE_BIT  = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       req_mode,
  input  logic             tx_busy,
  input  logic             bus_rx,
  input  logic             bit_tick,
  output logic [2:0]       cur_mode,
  output logic             tx_en,
  output logic             ack_en,
  output logic             loop_sel,
  output logic             accept_bad,
  output logic             clk_en,
  output logic             err_clr,
  output logic [IRQ_W-1:0] irq_mask
);
  localparam int CW = $clog2(IDLE_BITS + 1);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_BITS);
  localparam logic [2:0] M_CFG = 3'd0, M_DIS = 3'd1, M_NRM = 3'd2,
                         M_LSN = 3'd3, M_LPB = 3'd4, M_ERR = 3'd5;
  localparam logic [IRQ_W-1:0] WAKE_ONLY = IRQ_W'(1) << WAKE_BIT;

  logic [CW-1:0] idle_cnt;
  logic [2:0]    mode, nxt;
  wire bus_idle = (idle_cnt == IDLE_MAX);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                 idle_cnt <= '0;
    else if (bit_tick && !bus_rx) idle_cnt <= '0;
    else if (bit_tick && !bus_idle) idle_cnt <= idle_cnt + 1'b1;

  always_comb begin
    nxt = mode;
    case (req_mode)
      M_CFG: if (!tx_busy) nxt = M_CFG;
      M_DIS: if (mode == M_CFG || bus_idle) nxt = M_DIS;
      M_NRM, M_LSN, M_LPB, M_ERR: nxt = req_mode;
      default: nxt = mode;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mode <= M_CFG;
    else        mode <= nxt;

  assign cur_mode   = mode;
  assign tx_en      = (mode == M_NRM);
  assign ack_en     = (mode == M_NRM);
  assign loop_sel   = (mode == M_LPB);
  assign accept_bad = (mode == M_LSN) || (mode == M_ERR);
  assign clk_en     = (mode != M_DIS);
  assign err_clr    = (mode == M_CFG);
  assign irq_mask   = (mode == M_DIS) ? WAKE_ONLY : {IRQ_W{1'b1}};
endmodule

// File: rtl/can_mode_seq_chk.sv
module can_mode_seq_chk #(
  parameter int IDLE_BITS = 11,
  parameter int IRQ_W     = 8,
  parameter int WAKE_BIT  = 0,
  parameter int CW        = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       req_mode,
  input logic             tx_busy,
  input logic             bus_rx,
  input logic             bit_tick,
  input logic [2:0]       cur_mode,
  input logic             tx_en,
  input logic             ack_en,
  input logic             clk_en,
  input logic [IRQ_W-1:0] irq_mask,
  input logic [CW-1:0]    idle_cnt
);
  localparam logic [CW-1:0] IDLE_MAX = CW'(IDLE_BITS);
  localparam logic [IRQ_W-1:0] WAKE_ONLY = IRQ_W'(1) << WAKE_BIT;

  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 3'd0 && tx_busy && cur_mode != 3'd0) |=> cur_mode != 3'd0);
  // R12
  bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode > 3'd5) |=> $stable(cur_mode));
  // R5
  dis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_mode == 3'd1 && cur_mode != 3'd0 && cur_mode != 3'd1 && idle_cnt != IDLE_MAX)
    |=> cur_mode != 3'd1);
  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && bus_rx && idle_cnt == IDLE_MAX) |=> idle_cnt == IDLE_MAX);
  // R4
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !bus_rx) |=> idle_cnt == '0);
  // R6
  dis_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == 3'd1) |-> (!clk_en && !tx_en && irq_mask == WAKE_ONLY));
  // R7
  tx_only_nrm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_en |-> (ack_en && cur_mode == 3'd2));
endmodule

bind can_mode_seq can_mode_seq_chk #(
  .IDLE_BITS(IDLE_BITS), .IRQ_W(IRQ_W), .WAKE_BIT(WAKE_BIT), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .tx_busy(tx_busy),
  .bus_rx(bus_rx), .bit_tick(bit_tick), .cur_mode(cur_mode), .tx_en(tx_en),
  .ack_en(ack_en), .clk_en(clk_en), .irq_mask(irq_mask), .idle_cnt(idle_cnt)
);

// File: tb/can_mode_seq_bench.sv
`timescale 1ns/1ps
module can_mode_seq_bench;
  localparam int IDLE = 11;
  logic clk = 0, rst_n = 0;
  logic [2:0] req_mode = 3'd0;
  logic tx_busy = 0, bus_rx = 1, bit_tick = 0;
  logic [2:0] cur_mode;
  logic tx_en, ack_en, loop_sel, accept_bad, clk_en, err_clr;
  logic [7:0] irq_mask;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  can_mode_seq u_can_mode_seq (
    .clk(clk), .rst_n(rst_n), .req_mode(req_mode), .tx_busy(tx_busy),
    .bus_rx(bus_rx), .bit_tick(bit_tick), .cur_mode(cur_mode), .tx_en(tx_en),
    .ack_en(ack_en), .loop_sel(loop_sel), .accept_bad(accept_bad),
    .clk_en(clk_en), .err_clr(err_clr), .irq_mask(irq_mask));

  logic [2:0] m_mode;
  int m_cnt;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_mode <= 3'd0; m_cnt <= 0; end
    else begin
      m_mode <= next_mode(m_mode, req_mode, tx_busy, m_cnt);
      if (bit_tick) m_cnt <= bus_rx ? ((m_cnt < IDLE) ? m_cnt + 1 : IDLE) : 0;
    end

  function automatic logic [2:0] next_mode(logic [2:0] m, logic [2:0] r, logic busy, int cnt);
    case (r)
      3'd0: return busy ? m : 3'd0;
      3'd1: return (m == 3'd0 || cnt == IDLE) ? 3'd1 : m;
      3'd2, 3'd3, 3'd4, 3'd5: return r;
      default: return m;
    endcase
  endfunction

  // packed {tx_en, ack_en, loop_sel, accept_bad, clk_en, err_clr, irq_mask}
  function automatic logic [13:0] exp_out(logic [2:0] m);
    case (m)
      3'd0: return {6'b000011, 8'hFF};
      3'd1: return {6'b000000, 8'h01};
      3'd2: return {6'b110010, 8'hFF};
      3'd3: return {6'b000110, 8'hFF};
      3'd4: return {6'b001010, 8'hFF};
      3'd5: return {6'b000110, 8'hFF};
      default: return 14'h0;
    endcase
  endfunction

  function automatic string mode_tag(logic [2:0] m);
    case (m)
      3'd0: return "R3"; 3'd1: return "R6"; 3'd2: return "R7";
      3'd3: return "R8"; 3'd4: return "R9"; default: return "R10";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cmp_all(string mtag);
    check(mtag, {29'd0, cur_mode}, {29'd0, m_mode});
    check(mode_tag(m_mode),
          {18'd0, tx_en, ack_en, loop_sel, accept_bad, clk_en, err_clr, irq_mask},
          {18'd0, exp_out(m_mode)});
  endtask

  task automatic step(logic [2:0] r, logic busy, logic rx, logic tick);
    req_mode = r; tx_busy = busy; bus_rx = rx; bit_tick = tick;
    @(posedge clk); @(negedge clk);
    cmp_all("R11 mode");
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (2) @(negedge clk);
    // R1 reset state
    check("R1 mode", {29'd0, cur_mode}, 32'd0);
    check("R1 err_clr", {31'd0, err_clr}, 32'd1);
    check("R1 irq_mask", {24'd0, irq_mask}, 32'hFF);
    rst_n = 1;
    @(negedge clk);
    // R5 disable granted at once from configuration
    step(3'd1, 0, 1, 0);
    check("R5 immediate", {29'd0, cur_mode}, 32'd1);
    check("R6 clk_en", {31'd0, clk_en}, 32'd0);
    check("R6 irq_mask", {24'd0, irq_mask}, 32'h01);
    step(3'd2, 0, 1, 0);
    check("R11 normal", {29'd0, cur_mode}, 32'd2);
    // R2 configuration held while busy
    for (int i = 0; i < 3; i++) begin
      step(3'd0, 1, 1, 0);
      check("R2 held", {29'd0, cur_mode}, 32'd2);
    end
    step(3'd0, 0, 1, 0);
    check("R2 granted", {29'd0, cur_mode}, 32'd0);
    step(3'd2, 0, 1, 0);
    // R4 counter cleared by dominant tick
    for (int i = 0; i < 10; i++) step(3'd1, 0, 1, 1);
    step(3'd1, 0, 0, 1);
    check("R4 dominant clears", {29'd0, cur_mode}, 32'd2);
    for (int i = 0; i < 10; i++) step(3'd1, 0, 1, 1);
    check("R5 ten bits", {29'd0, cur_mode}, 32'd2);
    step(3'd1, 0, 1, 1);
    check("R5 eleventh bit", {29'd0, cur_mode}, 32'd2);
    step(3'd1, 0, 1, 0);
    check("R5 idle grant", {29'd0, cur_mode}, 32'd1);
    step(3'd4, 0, 1, 0);
    check("R9 loop", {31'd0, loop_sel}, 32'd1);
    // R12 undefined codes ignored
    step(3'd6, 0, 1, 1);
    check("R12 code6", {29'd0, cur_mode}, 32'd4);
    step(3'd7, 1, 0, 1);
    check("R12 code7", {29'd0, cur_mode}, 32'd4);
    step(3'd5, 0, 1, 0);
    check("R10 accept_bad", {31'd0, accept_bad}, 32'd1);
    step(3'd3, 0, 1, 0);
    check("R8 tx_en", {31'd0, tx_en}, 32'd0);
    for (int i = 0; i < 4000; i++)
      step(3'($urandom % 8), ($urandom % 4) == 0, ($urandom % 32) != 0, $urandom % 2);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule